// File: doc/BRIEF.md
# I2C Master SCL Generator with Clock Synchronization

This block produces the SCL clock of an I2C master from the peripheral clock. It does not run a free divider. Each phase is timed against the level it actually sees on the open-drain SCL line. The block asserts a pull-down enable for a programmed number of cycles, then releases the line. It starts counting the high time only once the resynchronized line reads high. A slow rise, a slave that stretches the clock, or another master that holds SCL low therefore all lengthen the released time.

If another device pulls the line low while the high count is still running, the block ends its high phase at once and starts a fresh low phase. This gives the wired-AND clock synchronization that is needed when several masters share the bus. Two pairs of low and high counts are provided, one for standard-rate and one for fast-rate timing, and a mode pin selects between them. A one-cycle strobe marks each change of the block's own phase, so that a data shifter can place and sample SDA. All pins are plain control and status levels. No data stream crosses the block's edge, so there is no valid/ready handshake.

Top module: `i2c_scl_pacer`

## Requirements
- R1: After reset, and while `enable` is low, `scl_pull` is 0 and both `rise_stb` and `fall_stb` are 0.
- R2: Each low phase holds `scl_pull` at 1 for exactly Leff cycles, where Leff is the low count of the selected pair after clamping. The count is not shortened by the line level.
- R3: When the line simply follows `scl_pull`, each released period lasts exactly Heff+3 cycles. Heff is the clamped high count. The line passes through a two-flop synchronizer, and the high count loads on the cycle after the synchronized level reads high.
- R4: If a slave keeps SCL low for N cycles after the release, the released period grows by exactly N cycles, to N+3+Heff. The high count does not run while the line reads low.
- R5: If another master pulls SCL low j cycles after the release (j ≥ 1), the block asserts `scl_pull` again after min(j, Heff)+3 released cycles. It then runs a full low phase of Leff cycles.
- R6: `fall_stb` is 1 for exactly the first cycle of every low phase and `rise_stb` for exactly the first released cycle. The two strobes are never 1 together.
- R7: A count below 4 is clamped up to 4 (Leff = max(count, 4), and the same for Heff). A count of 4 or above is used as given.
- R8: With `mode_fast` = 0 the pair `std_low`/`std_high` is used, and with `mode_fast` = 1 the pair `fast_low`/`fast_high`. The selected count is read when its phase begins.
- R9: When `enable` rises, the first low phase begins on the next clock edge with `fall_stb`. When `enable` falls, `scl_pull` is released on the next edge with no strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Run the clock generator |
| mode_fast | input | 1 | 0 selects the standard count pair, 1 the fast pair |
| std_low | input | CNT_W | Low-phase count, standard rate |
| std_high | input | CNT_W | High-phase count, standard rate |
| fast_low | input | CNT_W | Low-phase count, fast rate |
| fast_high | input | CNT_W | High-phase count, fast rate |
| scl_line | input | 1 | Observed level of the SCL bus line (asynchronous) |
| scl_pull | output | 1 | 1 drives SCL low; 0 releases it |
| rise_stb | output | 1 | One-cycle pulse on the first released cycle |
| fall_stb | output | 1 | One-cycle pulse on the first low-phase cycle |

## Verification
The hardest case to bring about from the ports is another master cutting the high phase short. The external low must arrive after the block has seen the line high and loaded its high count, but before that count expires. The bench models the bus as the wired-AND of `scl_pull`, a slave stretch term and a second-master term. It starts those terms a chosen number of cycles after each `rise_stb`, sweeps the offset across and past the high count, and checks the released length against min(j, Heff)+3. An exhaustive sweep of small counts in both modes covers the clamp and the selection of the count pair.

// File: rtl/i2c_scl_pacer_pkg.sv
package i2c_scl_pacer_pkg;

  // Shortest phase the pacer will ever time, in clock cycles
  localparam int unsigned PHASE_FLOOR = 4;

  typedef enum logic [1:0] {
    PH_OFF  = 2'd0,
    PH_LOW  = 2'd1,
    PH_WAIT = 2'd2,
    PH_HIGH = 2'd3
  } phase_t;

endpackage

// File: rtl/scl_line_sync.sv
module scl_line_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_async,
  output logic line_sync
);

  logic [STAGES-1:0] chain;

  // The idle bus is high, so every stage resets to 1
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '1;
    else        chain <= {chain[STAGES-2:0], line_async};
  end

  assign line_sync = chain[STAGES-1];

endmodule

// File: rtl/scl_count_select.sv
module scl_count_select #(
  parameter int unsigned CNT_W = 8,
  parameter int unsigned FLOOR = 4
) (
  input  logic             mode_fast,
  input  logic [CNT_W-1:0] std_low,
  input  logic [CNT_W-1:0] std_high,
  input  logic [CNT_W-1:0] fast_low,
  input  logic [CNT_W-1:0] fast_high,
  output logic [CNT_W-1:0] low_eff,
  output logic [CNT_W-1:0] high_eff
);

  localparam logic [CNT_W-1:0] FLOOR_V = CNT_W'(FLOOR);

  logic [CNT_W-1:0] raw   [2];
  logic [CNT_W-1:0] clamp [2];

  assign raw[0] = mode_fast ? fast_low  : std_low;
  assign raw[1] = mode_fast ? fast_high : std_high;

  // The same clamp serves the low lane (0) and the high lane (1)
  for (genvar g = 0; g < 2; g++) begin : g_clamp
    assign clamp[g] = (raw[g] < FLOOR_V) ? FLOOR_V : raw[g];
  end

  assign low_eff  = clamp[0];
  assign high_eff = clamp[1];

endmodule

// File: rtl/scl_phase_fsm.sv
module scl_phase_fsm
  import i2c_scl_pacer_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             line_hi,
  input  logic [CNT_W-1:0] low_eff,
  input  logic [CNT_W-1:0] high_eff,
  output logic             scl_pull,
  output logic             rise_stb,
  output logic             fall_stb
);

  phase_t           st;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= PH_OFF;
      cnt      <= '0;
      scl_pull <= 1'b0;
      rise_stb <= 1'b0;
      fall_stb <= 1'b0;
    end else begin
      rise_stb <= 1'b0;
      fall_stb <= 1'b0;
      if (!enable) begin
        st       <= PH_OFF;
        cnt      <= '0;
        scl_pull <= 1'b0;
      end else begin
        unique case (st)
          PH_OFF: begin
            st       <= PH_LOW;
            scl_pull <= 1'b1;
            fall_stb <= 1'b1;
            cnt      <= low_eff - 1'b1;
          end
          PH_LOW: begin
            if (cnt == '0) begin
              st       <= PH_WAIT;
              scl_pull <= 1'b0;
              rise_stb <= 1'b1;
            end else begin
              cnt <= cnt - 1'b1;
            end
          end
          PH_WAIT: begin
            // Hold off the high count until the line is really high
            if (line_hi) begin
              st  <= PH_HIGH;
              cnt <= high_eff - 1'b1;
            end
          end
          PH_HIGH: begin
            // Another device pulling low, or our own count running out
            if (!line_hi || cnt == '0) begin
              st       <= PH_LOW;
              scl_pull <= 1'b1;
              fall_stb <= 1'b1;
              cnt      <= low_eff - 1'b1;
            end else begin
              cnt <= cnt - 1'b1;
            end
          end
          default: st <= PH_OFF;
        endcase
      end
    end
  end

  a_r6_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(rise_stb && fall_stb));

  a_r6_fall_marks_pull: assert property (@(posedge clk) disable iff (!rst_n)
    fall_stb |-> (scl_pull && !$past(scl_pull)));

  a_r6_rise_marks_release: assert property (@(posedge clk) disable iff (!rst_n)
    rise_stb |-> (!scl_pull && $past(scl_pull)));

  a_r9_disable_releases: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!scl_pull && !rise_stb && !fall_stb));

  a_r4_wait_while_low: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && st == PH_WAIT && !line_hi) |=> !scl_pull);

  a_r5_cut_high: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && st == PH_HIGH && !line_hi) |=> (scl_pull && fall_stb));

  a_r3_high_after_seen: assert property (@(posedge clk) disable iff (!rst_n)
    (st == PH_HIGH && $past(st) == PH_WAIT) |-> $past(line_hi));

endmodule

// File: rtl/i2c_scl_pacer.sv
module i2c_scl_pacer
  import i2c_scl_pacer_pkg::*;
#(
  parameter int unsigned CNT_W    = 8,
  parameter int unsigned SYNC_STG = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             mode_fast,
  input  logic [CNT_W-1:0] std_low,
  input  logic [CNT_W-1:0] std_high,
  input  logic [CNT_W-1:0] fast_low,
  input  logic [CNT_W-1:0] fast_high,
  input  logic             scl_line,
  output logic             scl_pull,
  output logic             rise_stb,
  output logic             fall_stb
);

  logic             line_hi;
  logic [CNT_W-1:0] low_eff;
  logic [CNT_W-1:0] high_eff;

  scl_line_sync #(.STAGES(SYNC_STG)) u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .line_async (scl_line),
    .line_sync  (line_hi)
  );

  scl_count_select #(.CNT_W(CNT_W), .FLOOR(PHASE_FLOOR)) u_sel (
    .mode_fast (mode_fast),
    .std_low   (std_low),
    .std_high  (std_high),
    .fast_low  (fast_low),
    .fast_high (fast_high),
    .low_eff   (low_eff),
    .high_eff  (high_eff)
  );

  scl_phase_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (enable),
    .line_hi  (line_hi),
    .low_eff  (low_eff),
    .high_eff (high_eff),
    .scl_pull (scl_pull),
    .rise_stb (rise_stb),
    .fall_stb (fall_stb)
  );

  a_r1_quiet_in_reset_after: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable && !$past(enable)) |-> (!scl_pull && !rise_stb && !fall_stb));

endmodule

// File: tb/i2c_scl_pacer_bench.sv
module i2c_scl_pacer_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       enable = 1'b0;
  logic       mode_fast = 1'b0;
  logic [7:0] std_low = 8'd0, std_high = 8'd0, fast_low = 8'd0, fast_high = 8'd0;
  logic       stretch = 1'b0;
  logic       other = 1'b0;
  logic       scl_line;
  logic       scl_pull, rise_stb, fall_stb;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  // Wired-AND bus: any of three devices can hold the line low
  assign scl_line = ~(scl_pull | stretch | other);

  i2c_scl_pacer u_i2c_scl_pacer (
    .clk(clk), .rst_n(rst_n), .enable(enable), .mode_fast(mode_fast),
    .std_low(std_low), .std_high(std_high), .fast_low(fast_low), .fast_high(fast_high),
    .scl_line(scl_line), .scl_pull(scl_pull), .rise_stb(rise_stb), .fall_stb(fall_stb)
  );

  function automatic int eff(input int x);
    return (x < 4) ? 4 : x;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Disable, load counts, re-enable; returns at the negedge of the first low cycle
  task automatic restart(input logic m, input int sl, input int sh, input int fl, input int fh);
    @(negedge clk);
    enable = 1'b0;
    repeat (4) @(negedge clk);
    mode_fast = m;
    std_low = 8'(sl); std_high = 8'(sh); fast_low = 8'(fl); fast_high = 8'(fh);
    enable = 1'b1;
    @(negedge clk);
    check("R9 pull on enable", int'(scl_pull), 1);
    check("R9 fall strobe on enable", int'(fall_stb), 1);
  endtask

  // Starts at a negedge with fall_stb seen; ends at the next such negedge
  task automatic period(input int n_str, input int j_cut, output int lo, output int hi);
    lo = 0;
    while (scl_pull) begin
      lo++;
      @(negedge clk);
    end
    check("R6 rise strobe", int'(rise_stb), 1);
    hi = 0;
    while (1) begin
      stretch = (hi < n_str);
      other   = (j_cut > 0) && (hi >= j_cut) && (hi < j_cut + 2);
      if (scl_pull) break;
      hi++;
      @(negedge clk);
    end
    stretch = 1'b0;
    other   = 1'b0;
    check("R6 fall strobe", int'(fall_stb), 1);
  endtask

  initial begin
    int lo, hi;
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1 pull in reset", int'(scl_pull), 0);
    check("R1 strobes in reset", int'(rise_stb | fall_stb), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 pull idle", int'(scl_pull), 0);
    check("R1 strobes idle", int'(rise_stb | fall_stb), 0);

    // R2 R3 R7 R8: sweep small counts in both modes; the other pair is a decoy
    for (int m = 0; m < 2; m++) begin
      for (int l = 0; l < 10; l++) begin
        for (int h = 0; h < 10; h++) begin
          if (m == 0) restart(1'b0, l, h, l + 6, h + 7);
          else        restart(1'b1, l + 6, h + 7, l, h);
          period(0, 0, lo, hi);
          check("R2 R7 R8 low length", lo, eff(l));
          check("R3 R7 R8 released length", hi, eff(h) + 3);
        end
      end
    end

    // R2 R3: second period in a row keeps the same lengths
    restart(1'b0, 5, 6, 9, 9);
    period(0, 0, lo, hi);
    period(0, 0, lo, hi);
    check("R2 steady low", lo, 5);
    check("R3 steady released", hi, 9);

    // R4: slave stretch for n cycles after release
    for (int n = 1; n <= 6; n++) begin
      restart(1'b0, 5, 6, 9, 9);
      period(n, 0, lo, hi);
      check("R4 stretched released length", hi, n + 3 + 6);
      period(0, 0, lo, hi);
      check("R4 next low unaffected", lo, 5);
    end

    // R5: another master pulls low j cycles after release
    for (int j = 1; j <= 8; j++) begin
      restart(1'b1, 9, 9, 5, 6);
      period(0, j, lo, hi);
      check("R5 cut released length", hi, ((j < 6) ? j : 6) + 3);
      period(0, 0, lo, hi);
      check("R5 following low length", lo, 5);
    end

    // R9: disable in the middle of a low phase
    restart(1'b0, 8, 8, 4, 4);
    repeat (2) @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    check("R9 pull after disable", int'(scl_pull), 0);
    check("R9 no strobe on disable", int'(rise_stb | fall_stb), 0);
    repeat (5) @(negedge clk);
    check("R1 stays released when off", int'(scl_pull), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule